// File: doc/BRIEF.md
# Display PLL Post-Divider Clock Tree

This block turns a fast VCO clock into the two rates a display link needs: a pixel rate and a byte rate. The whole tree runs in the VCO clock domain. Every stage is a clock-enable counter, so each output is a single-cycle tick that marks one period of the divided clock. A downstream gate or enable can then use that tick.

The pixel branch is one programmable divider fed straight from the VCO. Its 8-bit setting gives a ratio of setting + 1. The byte branch has a 2-way source select. One source is the raw VCO. The other is the indirect path: a 4-bit programmable divider followed by a fixed halving stage. A fixed divide-by-4 stage follows the selected source.

Divider settings and the source select are sampled only at the end of an output period. A change therefore never cuts a period short. After reset every programmable divider behaves as a pass-through and the byte branch uses the raw VCO until the first period boundary.

Top module: `pll_postdiv_tree`

## Requirements
- R1: While `rst_n` is low at a rising edge, `pix_tick` and `byte_tick` are both low after that edge.
- R2: With a steady `div3_cfg`, `pix_tick` pulses once every `div3_cfg + 1` VCO cycles. A setting of 0 holds `pix_tick` high every cycle.
- R3: With `byte_src_cfg` = 0 (raw VCO source), `byte_tick` pulses once every 4 VCO cycles, whatever `div1_cfg` holds.
- R4: With `byte_src_cfg` = 1 (indirect source), `byte_tick` pulses once every `8 * (div1_cfg + 1)` VCO cycles.
- R5: A new `div3_cfg` takes effect at the next `pix_tick`. The pixel period in progress when it changes completes with the old ratio.
- R6: A new `byte_src_cfg` takes effect only at a `byte_tick` boundary. The byte period in progress completes on the old source, and `byte_tick` is never high on two consecutive cycles.
- R7: After reset is released, the tree starts in pass-through with the raw source, regardless of the settings:
  - the first `pix_tick` follows the first rising edge;
  - the first `byte_tick` follows the fourth rising edge.
- R8: The pixel period does not depend on `byte_src_cfg` or `div1_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO clock; the only clock of the block |
| rst_n | input | 1 | Synchronous active-low reset |
| div1_cfg | input | 4 | Indirect-path divider setting, ratio = value + 1 |
| div3_cfg | input | 8 | Pixel divider setting, ratio = value + 1 |
| byte_src_cfg | input | 1 | Byte source select: 0 raw VCO, 1 indirect halved path |
| pix_tick | output | 1 | One-cycle pulse per pixel clock period |
| byte_tick | output | 1 | One-cycle pulse per byte clock period |

## Verification
- **Pixel divider.** It is swept over the settings 0, 1, 2, 7 and 255. Setting 0 exposes a pass-through that fails to tick every cycle. Setting 255 exposes counter-width or compare errors at the full ratio.
- **Byte branch, raw source.** It is run with a nonzero `div1_cfg`, which shows whether that setting leaks into the raw path.
- **Byte branch, indirect source.** It is run at the ratios 1, 3 and 16, which separates the halving stage from the programmable stage.
- **Mid-period changes.** The pixel setting and the source select are each changed right after an output tick. The measured intervals then show whether the old period was allowed to finish or was cut.
- **Reset release.** It is done with large settings already applied. This separates a true pass-through start from a design that uses the settings immediately.

// File: rtl/pdt_pkg.sv
// Package: shared types of the post-divider tree.
// Assumes: nothing beyond IEEE 1800-2017.
package pdt_pkg;
    typedef enum logic {
        BYTE_SRC_VCO  = 1'b0,
        BYTE_SRC_HALF = 1'b1
    } byte_src_e;
endpackage

// File: rtl/pdt_ratio_div.sv
// Module: programmable clock-enable divider. Counts enabled cycles and
// raises tick_o for one cycle every ratio+1 enables.
// Assumes: ratio_i is sampled only when a period completes, so a change
// never shortens the period in progress. Reset gives ratio 0 (pass-through).
module pdt_ratio_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] ratio_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] ratio_q;
    logic         wrap;

    assign wrap = en_i && (cnt_q == ratio_q);

    // Count enables; at a wrap, restart the count and take the new ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= '0;
            tick_o  <= 1'b0;
        end else begin
            tick_o <= wrap;
            if (wrap) begin
                cnt_q   <= '0;
                ratio_q <= ratio_i;
            end else if (en_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pdt_fixed_div.sv
// Module: fixed clock-enable divider by N.
// wrap_o is combinational and high on the enabled cycle that ends a period.
// Assumes: N >= 2.
module pdt_fixed_div #(
    parameter int N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic wrap_o
);
    localparam int CW = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt_q;

    assign wrap_o = en_i && (cnt_q == LAST);

    // Advance on every enable and fold back to zero after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pdt_src_sel.sv
// Module: glitch-free source select for the byte branch.
// The select is loaded only when load_i marks the end of a byte period.
// Assumes: the raw VCO source is an enable that is always high.
module pdt_src_sel
    import pdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel_i,
    input  logic      load_i,
    input  logic      alt_en_i,
    output logic      en_o,
    output byte_src_e src_o
);
    // Hold the active source; update it only at a byte boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_o <= BYTE_SRC_VCO;
        end else if (load_i) begin
            src_o <= byte_src_e'(sel_i);
        end
    end

    // Route the enable of the active source to the next stage.
    always_comb begin
        en_o = (src_o == BYTE_SRC_HALF) ? alt_en_i : 1'b1;
    end
endmodule

// File: rtl/pll_postdiv_tree.sv
// Module: post-divider tree behind a display PLL VCO.
//   pixel: VCO -> ratio divider (div3_cfg+1)                -> pix_tick
//   byte : VCO or (VCO -> ratio divider (div1_cfg+1) -> /2) -> /4 -> byte_tick
// Assumes: one clock domain (the VCO). Every stage is an enable counter.
module pll_postdiv_tree
    import pdt_pkg::*;
#(
    parameter int DIV1_W = 4,
    parameter int DIV3_W = 8,
    parameter int HALF_N = 2,
    parameter int BYTE_N = 4
) (
    input  logic              vco_clk,
    input  logic              rst_n,
    input  logic [DIV1_W-1:0] div1_cfg,
    input  logic [DIV3_W-1:0] div3_cfg,
    input  logic              byte_src_cfg,
    output logic              pix_tick,
    output logic              byte_tick
);
    logic      div1_tick;
    logic      half_wrap;
    logic      byte_en;
    logic      byte_wrap;
    byte_src_e byte_src_q;

    pdt_ratio_div #(.W(DIV3_W)) u_pix_div (
        .clk    (vco_clk),
        .rst_n  (rst_n),
        .en_i   (1'b1),
        .ratio_i(div3_cfg),
        .tick_o (pix_tick)
    );

    pdt_ratio_div #(.W(DIV1_W)) u_div1 (
        .clk    (vco_clk),
        .rst_n  (rst_n),
        .en_i   (1'b1),
        .ratio_i(div1_cfg),
        .tick_o (div1_tick)
    );

    pdt_fixed_div #(.N(HALF_N)) u_half (
        .clk   (vco_clk),
        .rst_n (rst_n),
        .en_i  (div1_tick),
        .wrap_o(half_wrap)
    );

    pdt_src_sel u_sel (
        .clk     (vco_clk),
        .rst_n   (rst_n),
        .sel_i   (byte_src_cfg),
        .load_i  (byte_wrap),
        .alt_en_i(half_wrap),
        .en_o    (byte_en),
        .src_o   (byte_src_q)
    );

    pdt_fixed_div #(.N(BYTE_N)) u_byte_div (
        .clk   (vco_clk),
        .rst_n (rst_n),
        .en_i  (byte_en),
        .wrap_o(byte_wrap)
    );

    // Register the byte period boundary as a clean one-cycle tick.
    always_ff @(posedge vco_clk) begin
        if (!rst_n) begin
            byte_tick <= 1'b0;
        end else begin
            byte_tick <= byte_wrap;
        end
    end
endmodule

// File: rtl/pdt_checker.sv
// Module: property checker for pll_postdiv_tree, attached through bind.
// Gap counters bound the tick spacing, so no parameter-sized delay is unrolled.
module pdt_checker
    import pdt_pkg::*;
#(
    parameter int DIV1_W = 4,
    parameter int DIV3_W = 8,
    parameter int HALF_N = 2,
    parameter int BYTE_N = 4
) (
    input logic      clk,
    input logic      rst_n,
    input logic      pix_tick,
    input logic      byte_tick,
    input logic      byte_wrap,
    input byte_src_e byte_src_q
);
    localparam int PIX_MAX  = 2 ** DIV3_W;
    localparam int BYTE_MAX = 2 * HALF_N * BYTE_N * (2 ** DIV1_W);

    int pix_gap;
    int byte_gap;

    // Count the cycles since the last tick of each output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_gap  <= 0;
            byte_gap <= 0;
        end else begin
            pix_gap  <= pix_tick  ? 0 : pix_gap + 1;
            byte_gap <= byte_tick ? 0 : byte_gap + 1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!pix_tick && !byte_tick));

    // R2
    pix_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_gap < PIX_MAX);

    // R4
    byte_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_gap < BYTE_MAX);

    // R6
    src_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_wrap |=> byte_tick);

    // R6
    no_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_tick |=> !byte_tick);

    // R6
    src_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_src_q != $past(byte_src_q)) |-> byte_tick);
endmodule

bind pll_postdiv_tree pdt_checker #(
    .DIV1_W(DIV1_W),
    .DIV3_W(DIV3_W),
    .HALF_N(HALF_N),
    .BYTE_N(BYTE_N)
) u_pdt_chk (
    .clk       (vco_clk),
    .rst_n     (rst_n),
    .pix_tick  (pix_tick),
    .byte_tick (byte_tick),
    .byte_wrap (byte_wrap),
    .byte_src_q(byte_src_q)
);

// File: tb/pll_postdiv_tree_tb.sv
// Bench: directed scenarios for pll_postdiv_tree, one task per scenario.
// Outputs are sampled on the falling edge; inputs change on the falling edge.
module pll_postdiv_tree_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] div1_cfg = '0;
    logic [7:0] div3_cfg = '0;
    logic       byte_src_cfg = 1'b0;
    logic       pix_tick;
    logic       byte_tick;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    pll_postdiv_tree dut_i (
        .vco_clk     (clk),
        .rst_n       (rst_n),
        .div1_cfg    (div1_cfg),
        .div3_cfg    (div3_cfg),
        .byte_src_cfg(byte_src_cfg),
        .pix_tick    (pix_tick),
        .byte_tick   (byte_tick)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Cycles from the current tick to the next one (no initial wait).
    task automatic interval(input bit use_byte, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(use_byte ? byte_tick : pix_tick));
    endtask

    // Wait for a tick, then measure one full period.
    task automatic period(input bit use_byte, output int n);
        while (!(use_byte ? byte_tick : pix_tick)) @(negedge clk);
        interval(use_byte, n);
    endtask

    task automatic settle();
        repeat (600) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pix_tick in reset", int'(pix_tick), 0);
        check("R1 byte_tick in reset", int'(byte_tick), 0);
    endtask

    task automatic t_release();
        int first_pix = 0;
        int first_byte = 0;
        div3_cfg = 8'd4;
        div1_cfg = 4'd15;
        byte_src_cfg = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (pix_tick && first_pix == 0) first_pix = i;
            if (byte_tick && first_byte == 0) first_byte = i;
        end
        check("R7 first pix_tick cycle", first_pix, 1);
        check("R7 first byte_tick cycle", first_byte, 4);
    endtask

    task automatic t_pixel();
        int p;
        int vals[5] = '{0, 1, 2, 7, 255};
        foreach (vals[k]) begin
            div3_cfg = 8'(vals[k]);
            settle();
            period(1'b0, p);
            check("R2 pixel period", p, vals[k] + 1);
            period(1'b0, p);
            check("R2 pixel period repeat", p, vals[k] + 1);
        end
    endtask

    task automatic t_byte_raw();
        int p;
        byte_src_cfg = 1'b0;
        div1_cfg = 4'd9;
        settle();
        period(1'b1, p);
        check("R3 raw byte period", p, 4);
    endtask

    task automatic t_byte_half();
        int p;
        int vals[3] = '{0, 2, 15};
        byte_src_cfg = 1'b1;
        foreach (vals[k]) begin
            div1_cfg = 4'(vals[k]);
            settle();
            period(1'b1, p);
            check("R4 indirect byte period", p, 8 * (vals[k] + 1));
        end
    endtask

    task automatic t_pix_indep();
        int p;
        div3_cfg = 8'd6;
        byte_src_cfg = 1'b0;
        div1_cfg = 4'd3;
        settle();
        period(1'b0, p);
        check("R8 pixel period, raw byte source", p, 7);
        byte_src_cfg = 1'b1;
        div1_cfg = 4'd12;
        settle();
        period(1'b0, p);
        check("R8 pixel period, indirect byte source", p, 7);
    endtask

    task automatic t_pix_reconf();
        int p;
        div3_cfg = 8'd9;
        settle();
        while (!pix_tick) @(negedge clk);
        div3_cfg = 8'd2;
        interval(1'b0, p);
        check("R5 period in progress keeps old ratio", p, 10);
        interval(1'b0, p);
        check("R5 next period uses new ratio", p, 3);
    endtask

    task automatic t_src_switch();
        int p;
        byte_src_cfg = 1'b0;
        div1_cfg = 4'd0;
        settle();
        while (!byte_tick) @(negedge clk);
        byte_src_cfg = 1'b1;
        interval(1'b1, p);
        check("R6 period in progress keeps raw source", p, 4);
        interval(1'b1, p);
        check("R6 switch period not shorter than 4", int'(p >= 4 && p <= 8), 1);
        interval(1'b1, p);
        check("R6 period after switch", p, 8);
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_release();
        t_pixel();
        t_byte_raw();
        t_byte_half();
        t_pix_indep();
        t_pix_reconf();
        t_src_switch();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule